// File: doc/BRIEF.md
# Software-Loaded Translation Buffer with Zone Protection

This block holds a fully associative table of address translations that software fills one entry at a time. Each entry is loaded in two halves. The tag half carries the effective page, the page size, the valid flag and storage attributes, and it records the current process number. The data half carries the real page, the execute and write permissions and a zone selector. Both halves are written through the same index and data buses.

A lookup presents an effective address, an access kind (fetch, load or store) and the privilege level. The block compares the address against every entry at once and keeps the lowest-numbered hit. It reads the 2-bit zone code that the hit entry selects from a zone protection word, and combines that code with the privilege level and the entry's permissions. One cycle later it reports either a real address with the granted read and write rights, a protection fault, or a miss. A miss also loads a fault-address register and a syndrome register and raises a fetch-miss or a data-miss pulse.

A tag-half write changes the range that an entry maps. The block therefore reports the range the entry covered before the write and the range it covers after it, so that any cached copies of those translations can be dropped.

Top module: `zone_tlb`

## Requirements
- R1: `wr_index` selects the entry written by `wr_hi_en` or `wr_lo_en`. There are N_ENT entries (default 64), and every index from 0 to N_ENT-1 is reachable.
- R2: A tag write takes the page size code from `wr_data[9:7]`, the valid flag from `wr_data[6]` and the attribute byte from `wr_data[7:0]`. It takes the effective page from `wr_data[31:10]`, cleared below the page size. It stores `cur_pid` as the entry's process number and leaves the entry's data half unchanged.
- R3: A data write takes the real page from `wr_data[31:10]`, execute permission from bit 9, write permission from bit 8 and the zone selector from bits [7:4]. It leaves the entry's tag half and attribute byte unchanged.
- R4: The page size is 1 KiB × 4^code. Only address bits at or above log2(page size) are compared. The real address takes the real page bits above the page offset and the lookup address bits inside it.
- R5: An entry hits only when it is valid and its process number is either zero or equal to `cur_pid`.
- R6: When several entries hit, the entry with the lowest index supplies the result.
- R7: The zone code is `zone_prot[2z+1:2z]` for zone selector z. For a fetch, code 0 in user mode faults. Code 3 grants read and write. Every other case faults without execute permission; with it, the fetch grants read, plus write if the entry is writable.
- R8: For a load or store, code 0 in user mode faults. Code 3 grants read and write. Every other case grants read, plus write when the entry is writable, and a store to a non-writable entry faults.
- R9: The response is registered. It appears on the cycle after `lk_req` with `rsp_valid` high, and `rsp_status` is 0 for success, 1 for a miss and 2 for a protection fault. `rsp_raddr` is 0 unless the status is 0, and a miss grants no rights.
- R10: A miss pulses `imiss` for a fetch or `dmiss` for a load or store, and loads `fault_addr` with the lookup address. It loads `syndrome` with 0x00800000 for a store and 0 otherwise. Hits and protection faults leave both registers unchanged.
- R11: On the cycle after a tag write, `flush_old_v` is high when the entry was valid before the write, with that entry's old base and size code. `flush_new_v` is high when the written entry is valid, with its new aligned base and size code.
- R12: After reset every entry is invalid, and the response, miss and flush outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_hi_en | input | 1 | Write tag half of the indexed entry |
| wr_lo_en | input | 1 | Write data half of the indexed entry |
| wr_index | input | log2(N_ENT) | Entry index for writes |
| wr_data | input | 32 | Write data word |
| cur_pid | input | PID_W | Current process number |
| zone_prot | input | 32 | Sixteen 2-bit zone codes |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Effective address to translate |
| lk_kind | input | 2 | 0 fetch, 1 load, 2 store |
| lk_user | input | 1 | 1 for user mode, 0 for supervisor |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_status | output | 2 | 0 ok, 1 miss, 2 protection fault |
| rsp_raddr | output | 32 | Translated real address |
| rsp_rd | output | 1 | Read right granted |
| rsp_wr | output | 1 | Write right granted |
| rsp_attr | output | 8 | Attribute byte of the hit entry |
| imiss | output | 1 | Fetch miss pulse |
| dmiss | output | 1 | Data miss pulse |
| fault_addr | output | 32 | Address of the latest miss |
| syndrome | output | 32 | Syndrome of the latest miss |
| flush_old_v | output | 1 | Old range of a rewritten entry to be dropped |
| flush_old_base | output | 32 | Base of that old range |
| flush_old_szc | output | 3 | Size code of that old range |
| flush_new_v | output | 1 | New range of a written entry to be dropped |
| flush_new_base | output | 32 | Base of that new range |
| flush_new_szc | output | 3 | Size code of that new range |

## Verification
The bench sweeps every zone code against both privilege levels, all three access kinds and all four combinations of execute and write permission, and compares the status and granted rights with values worked out from the rules. This sweep catches a fetch that ignores the execute bit, or a user access under code 0 that is let through. It also sweeps all eight page sizes with in-page and just-outside addresses. A wrong mask would either merge neighbouring pages or splice the wrong bits into the real address. Further cases cover overlapping entries, where a design that picked the highest index returns the other real page, and process-number mismatch against a global entry. They also check the miss registers: a protection fault that disturbed them, or a swapped syndrome for stores, is visible at the ports.

// File: rtl/tlbz_pkg.sv
package tlbz_pkg;
   localparam int unsigned VA_W   = 32;
   localparam int unsigned PG_LSB = 10;
   localparam int unsigned PN_W   = VA_W - PG_LSB;
   localparam int unsigned ZSEL_W = 4;
   localparam int unsigned SZC_W  = 3;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2
   } acc_e;

   typedef enum logic [1:0] {
      ST_OK   = 2'd0,
      ST_MISS = 2'd1,
      ST_PROT = 2'd2
   } stat_e;

   localparam logic [VA_W-1:0] SYN_STORE = 32'h0080_0000;

   typedef struct packed {
      logic              vld;
      logic [PN_W-1:0]   epn;
      logic [SZC_W-1:0]  szc;
      logic [7:0]        attr;
      logic [PN_W-1:0]   rpn;
      logic              xp;
      logic              wp;
      logic [ZSEL_W-1:0] zsel;
   } ent_t;

   // ones on the page-number bits that lie inside a page of size code szc
   function automatic logic [PN_W-1:0] pn_mask(input logic [SZC_W-1:0] szc);
      return (PN_W'(1) << {szc, 1'b0}) - PN_W'(1);
   endfunction
endpackage

// File: rtl/tlbz_entry.sv
module tlbz_entry
   import tlbz_pkg::*;
#(
   parameter int unsigned PID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_hi,
   input  logic             we_lo,
   input  logic [VA_W-1:0]  wdata,
   input  logic [PID_W-1:0] cur_pid,
   input  logic [VA_W-1:0]  lk_addr,
   output ent_t             ent,
   output logic             hit
);
   logic [PID_W-1:0] pid_q;
   logic [PN_W-1:0]  in_mask;
   logic             pid_ok;

   assign in_mask = pn_mask(wdata[9:7]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent   <= '0;
         pid_q <= '0;
      end else begin
         if (we_hi) begin
            ent.szc  <= wdata[9:7];
            ent.epn  <= wdata[VA_W-1:PG_LSB] & ~in_mask;
            ent.vld  <= wdata[6];
            ent.attr <= wdata[7:0];
            pid_q    <= cur_pid;
         end
         if (we_lo) begin
            ent.rpn  <= wdata[VA_W-1:PG_LSB];
            ent.xp   <= wdata[9];
            ent.wp   <= wdata[8];
            ent.zsel <= wdata[7:4];
         end
      end
   end

   assign pid_ok = (pid_q == cur_pid) || (pid_q == '0);
   assign hit    = ent.vld && pid_ok &&
                   (((ent.epn ^ lk_addr[VA_W-1:PG_LSB]) & ~pn_mask(ent.szc)) == '0);

   // R3
   lo_keeps_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_lo && !we_hi) |=> (ent.epn == $past(ent.epn) && ent.vld == $past(ent.vld)
                             && ent.szc == $past(ent.szc) && ent.attr == $past(ent.attr)));
   // R2
   hi_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_hi && !we_lo) |=> (ent.rpn == $past(ent.rpn) && ent.zsel == $past(ent.zsel)
                             && ent.xp == $past(ent.xp) && ent.wp == $past(ent.wp)));
endmodule

// File: rtl/tlbz_prio.sv
module tlbz_prio #(
   parameter int unsigned N  = 64,
   parameter int unsigned IW = 6
) (
   input  logic [N-1:0]  hits,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) idx = IW'(i);
      end
   end
   assign any = |hits;
endmodule

// File: rtl/tlbz_perm.sv
module tlbz_perm
   import tlbz_pkg::*;
(
   input  logic [1:0] kind,
   input  logic       user,
   input  logic [1:0] code,
   input  logic       xp,
   input  logic       wp,
   output logic       g_rd,
   output logic       g_wr,
   output logic       deny
);
   always_comb begin
      g_rd = 1'b0;
      g_wr = 1'b0;
      deny = 1'b0;
      if (code == 2'd0 && user) begin
         deny = 1'b1;
      end else if (code == 2'd3) begin
         g_rd = 1'b1;
         g_wr = 1'b1;
      end else if (kind == ACC_FETCH) begin
         if (!xp) begin
            deny = 1'b1;
         end else begin
            g_rd = 1'b1;
            g_wr = wp;
         end
      end else begin
         g_rd = 1'b1;
         g_wr = wp;
         deny = (kind == ACC_STORE) && !wp;
      end
   end
endmodule

// File: rtl/zone_tlb.sv
module zone_tlb
   import tlbz_pkg::*;
#(
   parameter int unsigned N_ENT = 64,
   parameter int unsigned PID_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_hi_en,
   input  logic                     wr_lo_en,
   input  logic [$clog2(N_ENT)-1:0] wr_index,
   input  logic [VA_W-1:0]          wr_data,
   input  logic [PID_W-1:0]         cur_pid,
   input  logic [VA_W-1:0]          zone_prot,
   input  logic                     lk_req,
   input  logic [VA_W-1:0]          lk_addr,
   input  logic [1:0]               lk_kind,
   input  logic                     lk_user,
   output logic                     rsp_valid,
   output logic [1:0]               rsp_status,
   output logic [VA_W-1:0]          rsp_raddr,
   output logic                     rsp_rd,
   output logic                     rsp_wr,
   output logic [7:0]               rsp_attr,
   output logic                     imiss,
   output logic                     dmiss,
   output logic [VA_W-1:0]          fault_addr,
   output logic [VA_W-1:0]          syndrome,
   output logic                     flush_old_v,
   output logic [VA_W-1:0]          flush_old_base,
   output logic [SZC_W-1:0]         flush_old_szc,
   output logic                     flush_new_v,
   output logic [VA_W-1:0]          flush_new_base,
   output logic [SZC_W-1:0]         flush_new_szc
);
   localparam int unsigned IDX_W = $clog2(N_ENT);

   if (N_ENT < 2 || (N_ENT & (N_ENT - 1)) != 0) begin : g_bad_depth
      $error("zone_tlb: N_ENT must be a power of two of at least 2");
   end
   if (PID_W < 1) begin : g_bad_pid
      $error("zone_tlb: PID_W must be at least 1");
   end

   ent_t             ents [N_ENT];
   logic [N_ENT-1:0] hits;
   logic             hit_any;
   logic [IDX_W-1:0] hit_idx;

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      tlbz_entry #(.PID_W(PID_W)) u_ent (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_hi   (wr_hi_en && (wr_index == IDX_W'(i))),
         .we_lo   (wr_lo_en && (wr_index == IDX_W'(i))),
         .wdata   (wr_data),
         .cur_pid (cur_pid),
         .lk_addr (lk_addr),
         .ent     (ents[i]),
         .hit     (hits[i])
      );
   end

   tlbz_prio #(.N(N_ENT), .IW(IDX_W)) u_prio (
      .hits (hits),
      .any  (hit_any),
      .idx  (hit_idx)
   );

   // selected entry fields
   logic [PN_W-1:0] sel_rpn;
   logic [PN_W-1:0] sel_mask;
   logic [1:0]      sel_code;
   logic [VA_W-1:0] tr_addr;
   logic            g_rd;
   logic            g_wr;
   logic            deny;

   assign sel_rpn  = ents[hit_idx].rpn;
   assign sel_mask = pn_mask(ents[hit_idx].szc);
   assign sel_code = zone_prot[{ents[hit_idx].zsel, 1'b0} +: 2];
   assign tr_addr  = {(sel_rpn & ~sel_mask) | (lk_addr[VA_W-1:PG_LSB] & sel_mask),
                      lk_addr[PG_LSB-1:0]};

   tlbz_perm u_perm (
      .kind (lk_kind),
      .user (lk_user),
      .code (sel_code),
      .xp   (ents[hit_idx].xp),
      .wp   (ents[hit_idx].wp),
      .g_rd (g_rd),
      .g_wr (g_wr),
      .deny (deny)
   );

   // lookup response and miss registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_status <= ST_OK;
         rsp_raddr  <= '0;
         rsp_rd     <= 1'b0;
         rsp_wr     <= 1'b0;
         rsp_attr   <= '0;
         imiss      <= 1'b0;
         dmiss      <= 1'b0;
         fault_addr <= '0;
         syndrome   <= '0;
      end else begin
         rsp_valid <= lk_req;
         imiss     <= 1'b0;
         dmiss     <= 1'b0;
         if (lk_req) begin
            if (!hit_any) begin
               rsp_status <= ST_MISS;
               rsp_raddr  <= '0;
               rsp_rd     <= 1'b0;
               rsp_wr     <= 1'b0;
               rsp_attr   <= '0;
               fault_addr <= lk_addr;
               syndrome   <= (lk_kind == ACC_STORE) ? SYN_STORE : '0;
               imiss      <= (lk_kind == ACC_FETCH);
               dmiss      <= (lk_kind != ACC_FETCH);
            end else begin
               rsp_status <= deny ? ST_PROT : ST_OK;
               rsp_raddr  <= deny ? '0 : tr_addr;
               rsp_rd     <= g_rd;
               rsp_wr     <= g_wr;
               rsp_attr   <= ents[hit_idx].attr;
            end
         end
      end
   end

   // ranges to drop after a tag write
   logic [PN_W-1:0] new_epn;
   assign new_epn = wr_data[VA_W-1:PG_LSB] & ~pn_mask(wr_data[9:7]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_old_v    <= 1'b0;
         flush_old_base <= '0;
         flush_old_szc  <= '0;
         flush_new_v    <= 1'b0;
         flush_new_base <= '0;
         flush_new_szc  <= '0;
      end else begin
         flush_old_v <= wr_hi_en && ents[wr_index].vld;
         flush_new_v <= wr_hi_en && wr_data[6];
         if (wr_hi_en) begin
            flush_old_base <= {ents[wr_index].epn, {PG_LSB{1'b0}}};
            flush_old_szc  <= ents[wr_index].szc;
            flush_new_base <= {new_epn, {PG_LSB{1'b0}}};
            flush_new_szc  <= wr_data[9:7];
         end
      end
   end

   logic [N_ENT-1:0] below_sel;
   assign below_sel = (N_ENT'(1) << hit_idx) - N_ENT'(1);

   // R6
   lowest_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_any |-> (hits[hit_idx] && ((hits & below_sel) == '0)));
   // R9
   rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(lk_req));
   // R10
   miss_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (imiss || dmiss) |-> (rsp_status == ST_MISS && fault_addr == $past(lk_addr)));
   // R10
   fetch_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      imiss |-> (syndrome == '0 && !dmiss));
   // R9
   ok_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == ST_OK) |-> rsp_rd);
   // R11
   flush_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_old_v || flush_new_v) |-> $past(wr_hi_en));
endmodule

// File: tb/test_zone_tlb.sv
module test_zone_tlb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_hi_en = 1'b0;
   logic        wr_lo_en = 1'b0;
   logic [5:0]  wr_index = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  cur_pid = '0;
   logic [31:0] zone_prot = '0;
   logic        lk_req = 1'b0;
   logic [31:0] lk_addr = '0;
   logic [1:0]  lk_kind = '0;
   logic        lk_user = 1'b0;
   logic        rsp_valid;
   logic [1:0]  rsp_status;
   logic [31:0] rsp_raddr;
   logic        rsp_rd;
   logic        rsp_wr;
   logic [7:0]  rsp_attr;
   logic        imiss;
   logic        dmiss;
   logic [31:0] fault_addr;
   logic [31:0] syndrome;
   logic        flush_old_v;
   logic [31:0] flush_old_base;
   logic [2:0]  flush_old_szc;
   logic        flush_new_v;
   logic [31:0] flush_new_base;
   logic [2:0]  flush_new_szc;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   zone_tlb i_zone_tlb (
      .clk(clk), .rst_n(rst_n), .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en),
      .wr_index(wr_index), .wr_data(wr_data), .cur_pid(cur_pid), .zone_prot(zone_prot),
      .lk_req(lk_req), .lk_addr(lk_addr), .lk_kind(lk_kind), .lk_user(lk_user),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_raddr(rsp_raddr),
      .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_attr(rsp_attr), .imiss(imiss), .dmiss(dmiss),
      .fault_addr(fault_addr), .syndrome(syndrome),
      .flush_old_v(flush_old_v), .flush_old_base(flush_old_base), .flush_old_szc(flush_old_szc),
      .flush_new_v(flush_new_v), .flush_new_base(flush_new_base), .flush_new_szc(flush_new_szc)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr_hi(input int idx, input logic [31:0] d);
      @(negedge clk);
      wr_hi_en = 1'b1; wr_index = 6'(idx); wr_data = d;
      @(negedge clk);
      wr_hi_en = 1'b0;
   endtask

   task automatic wr_lo(input int idx, input logic [31:0] d);
      @(negedge clk);
      wr_lo_en = 1'b1; wr_index = 6'(idx); wr_data = d;
      @(negedge clk);
      wr_lo_en = 1'b0;
   endtask

   task automatic look(input logic [31:0] a, input logic [1:0] k, input logic u);
      @(negedge clk);
      lk_req = 1'b1; lk_addr = a; lk_kind = k; lk_user = u;
      @(negedge clk);
      lk_req = 1'b0;
   endtask

   // expects a successful translation
   task automatic exp_ok(input string req, input logic [31:0] ra);
      chk({req, " status"}, 32'(rsp_status), 32'd0);
      chk({req, " raddr"}, rsp_raddr, ra);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog act=running exp=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 rsp_valid", 32'(rsp_valid), 0);
      chk("R12 imiss", 32'(imiss), 0);
      chk("R12 flush", 32'({flush_old_v, flush_new_v}), 0);
      look(32'h1234_5678, 2'd1, 1'b0);
      chk("R12 empty table misses", 32'(rsp_status), 32'd1);
      chk("R9 rsp_valid", 32'(rsp_valid), 1);

      // R10 store miss
      look(32'h0BAD_0000, 2'd2, 1'b1);
      chk("R10 store miss status", 32'(rsp_status), 32'd1);
      chk("R10 dmiss", 32'({imiss, dmiss}), 32'b01);
      chk("R10 store syndrome", syndrome, 32'h0080_0000);
      chk("R10 fault_addr", fault_addr, 32'h0BAD_0000);
      chk("R9 miss raddr", rsp_raddr, 32'h0);
      chk("R9 miss rights", 32'({rsp_rd, rsp_wr}), 0);

      // R7 R8 zone sweep: zone z holds code z mod 4
      begin
         logic [31:0] zp = '0;
         for (int z = 0; z < 16; z++) zp[2*z +: 2] = 2'(z & 3);
         zone_prot = zp;
      end
      wr_hi(0, 32'h0001_0040);
      chk("R11 first write no old", 32'(flush_old_v), 0);
      chk("R11 first write new", 32'({flush_new_v, flush_new_base}), {1'b0, 32'h0001_0000} | 33'h1_0000_0000);
      for (int c = 0; c < 4; c++) begin
         for (int ex = 0; ex < 2; ex++) begin
            for (int w = 0; w < 2; w++) begin
               wr_lo(0, 32'h0020_0000 | 32'(ex << 9) | 32'(w << 8) | 32'((c + 4*w + 8*ex) << 4));
               for (int k = 0; k < 3; k++) begin
                  for (int u = 0; u < 2; u++) begin
                     int e_st; int e_rd; int e_wr;
                     string tag;
                     tag = (k == 0) ? "R7" : "R8";
                     if (u == 1 && c == 0) begin e_st = 2; e_rd = 0; e_wr = 0; end
                     else if (c == 3) begin e_st = 0; e_rd = 1; e_wr = 1; end
                     else if (k == 0) begin
                        if (ex == 0) begin e_st = 2; e_rd = 0; e_wr = 0; end
                        else begin e_st = 0; e_rd = 1; e_wr = w; end
                     end else begin
                        e_rd = 1; e_wr = w;
                        e_st = (k == 2 && w == 0) ? 2 : 0;
                     end
                     look(32'h0001_0123, 2'(k), u[0]);
                     chk($sformatf("%s status c%0d x%0d w%0d k%0d u%0d", tag, c, ex, w, k, u), 32'(rsp_status), 32'(e_st));
                     chk($sformatf("%s rd c%0d x%0d w%0d k%0d u%0d", tag, c, ex, w, k, u), 32'(rsp_rd), 32'(e_rd));
                     chk($sformatf("%s wr c%0d x%0d w%0d k%0d u%0d", tag, c, ex, w, k, u), 32'(rsp_wr), 32'(e_wr));
                     chk($sformatf("%s raddr c%0d x%0d w%0d k%0d u%0d", tag, c, ex, w, k, u), rsp_raddr,
                         (e_st == 0) ? 32'h0020_0123 : 32'h0);
                  end
               end
            end
         end
      end
      // R10 protection faults left the miss registers alone
      chk("R10 fault_addr kept", fault_addr, 32'h0BAD_0000);
      chk("R10 syndrome kept", syndrome, 32'h0080_0000);

      // R4 size sweep on entry 3, zone 3 (code 3)
      wr_lo(3, 32'h1234_5400 | 32'h30);
      for (int s = 0; s < 8; s++) begin
         logic [31:0] m; logic [31:0] base; logic [31:0] hi; logic [31:0] a; logic [31:0] prev;
         m    = (32'h1 << (10 + 2*s)) - 32'h1;
         hi   = 32'hABCD_EC00 | 32'(s << 7) | 32'h40 | 32'h15;
         base = 32'hABCD_EC00 & ~m;
         prev = 32'hABCD_EC00 & ~((32'h1 << (10 + 2*(s-1))) - 32'h1);
         wr_hi(3, hi);
         chk($sformatf("R11 new base s%0d", s), flush_new_base, base);
         chk($sformatf("R11 new szc s%0d", s), 32'({flush_new_v, flush_new_szc}), 32'(8 + s));
         if (s > 0) begin
            chk($sformatf("R11 old s%0d", s), 32'({flush_old_v, flush_old_szc}), 32'(8 + s - 1));
            chk($sformatf("R11 old base s%0d", s), flush_old_base, prev);
         end else begin
            chk("R11 old invalid", 32'(flush_old_v), 0);
         end
         a = base | (32'h5A5A_5A5A & m);
         look(a, 2'd1, 1'b1);
         exp_ok($sformatf("R4 in page s%0d", s), (32'h1234_5400 & ~m) | (a & m));
         chk($sformatf("R2 attr s%0d", s), 32'(rsp_attr), hi & 32'hFF);
         look(a ^ (32'h1 << (10 + 2*s)), 2'd1, 1'b1);
         chk($sformatf("R4 next page misses s%0d", s), 32'({rsp_status, dmiss}), 32'b011);
         chk($sformatf("R10 load syndrome s%0d", s), syndrome, 32'h0);
         chk($sformatf("R10 fault_addr s%0d", s), fault_addr, a ^ (32'h1 << (10 + 2*s)));
      end

      // R10 fetch miss
      look(32'h7777_0000, 2'd0, 1'b0);
      chk("R10 fetch miss pulses", 32'({imiss, dmiss}), 32'b10);
      chk("R10 fetch syndrome", syndrome, 32'h0);
      chk("R10 fetch fault_addr", fault_addr, 32'h7777_0000);

      // R5 process number matching
      cur_pid = 8'd5;
      wr_hi(7, 32'h4000_0040);
      wr_lo(7, 32'h0030_0030);
      look(32'h4000_0004, 2'd1, 1'b1);
      exp_ok("R5 own pid", 32'h0030_0004);
      cur_pid = 8'd6;
      look(32'h4000_0004, 2'd1, 1'b1);
      chk("R5 other pid misses", 32'(rsp_status), 32'd1);
      look(32'h0001_0010, 2'd1, 1'b1);
      exp_ok("R5 global entry", 32'h0020_0010);
      cur_pid = 8'd0;

      // R6 overlapping entries
      wr_hi(12, 32'h5000_0040);
      wr_lo(12, 32'h0200_0030);
      wr_hi(10, 32'h5000_0040);
      wr_lo(10, 32'h0100_0030);
      look(32'h5000_0008, 2'd2, 1'b0);
      exp_ok("R6 lowest index", 32'h0100_0008);
      wr_hi(10, 32'h5000_0000);
      chk("R11 invalidate old", 32'({flush_old_v, flush_new_v}), 32'b10);
      chk("R11 invalidate old base", flush_old_base, 32'h5000_0000);
      look(32'h5000_0008, 2'd2, 1'b0);
      exp_ok("R6 next entry", 32'h0200_0008);
      wr_lo(12, 32'h0300_0030);
      look(32'h5000_0008, 2'd1, 1'b0);
      exp_ok("R3 data write", 32'h0300_0008);
      chk("R3 tag kept", 32'(rsp_attr), 32'h40);
      wr_hi(12, 32'h5000_0045);
      look(32'h5000_0008, 2'd1, 1'b0);
      exp_ok("R2 data half kept", 32'h0300_0008);
      chk("R2 attr update", 32'(rsp_attr), 32'h45);

      // R1 highest index
      wr_hi(63, 32'h6000_0040);
      wr_lo(63, 32'h0400_0030);
      look(32'h6000_0100, 2'd0, 1'b1);
      exp_ok("R1 entry 63", 32'h0400_0100);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule